// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves 8-bit frames over a serial data pair using a shift clock. The shift clock comes from one of two places. It can be made inside the block by dividing the system clock, with the result driven on `sclk_o`. It can also come from an external pin, `sclk_i`, which the block synchronizes and edge-detects. The polarity input sets the idle level of the shift clock. The leading edge, the one that leaves the idle level, changes the outgoing bit. The trailing edge samples the incoming bit. Bits travel LSB first in both directions.

The transmitter starts every frame, so it also paces reception. Software puts a byte, or a dummy byte when it only wants to receive, into the transmit buffer. A frame starts when transmit enable is set. When flow control is enabled, the clear-to-send input must also be low. While the frame shifts, the contents of the transmit buffer appear on `txd_o`. Continuous receive mode removes the need for a new dummy byte before each frame: reading the receive buffer starts the next frame, which resends the last transmit byte. The receive side reports:

- a complete flag;
- a one-cycle interrupt pulse;
- a sticky overrun flag, raised when a frame reaches its 7th bit while the previous byte is still unread;
- a request-to-send output that goes high for the duration of each frame.

Top module: `csio_top`

## Requirements
- R1: No frame starts, and no shift clock edge is produced, unless `tx_en_i` is 1 and the transmit buffer holds a byte written at register address 0 (or a continuous-mode re-arm is pending). A write made while `tx_en_i` is 0 stays pending.
- R2: With the internal clock, each half period of `sclk_o` lasts baud+1 system clocks, where baud is the value at register address 2. `txd_o` changes on the leading edge and shows the transmit byte LSB first. The bit on `rxd_i` is sampled on the trailing edge and assembled LSB first into the receive buffer, which is read at register address 1.
- R3: When `clk_pol_i` is 0 the shift clock idles high, and when it is 1 it idles low. The leading edge always changes data and the trailing edge always samples it.
- R4: `tx_empty_o` is 1 after reset. A write to address 0 clears it, and it returns to 1 when the byte is loaded into the shift register at frame start.
- R5: When a frame ends with `rx_en_i` at 1 and no overrun occurred, `rx_done_o` rises and `rx_irq_o` pulses for exactly one cycle. A read of address 1 clears `rx_done_o`.
- R6: If a frame latches its 7th bit while `rx_done_o` is still 1, `overrun_o` rises. That frame still overwrites the receive buffer but raises no `rx_irq_o` pulse. `overrun_o` clears while `rx_en_i` is 0.
- R7: Outside continuous mode, reading the receive buffer does not start a frame. Each frame needs a new write to address 0.
- R8: With `cont_rx_i` at 1, a read of address 1 starts the next frame with no write, and the frame sends the last byte written to the transmit buffer again.
- R9: With `cts_en_i` at 1, a frame may start only while `cts_ni` is 0. A pending byte waits while `cts_ni` is 1.
- R10: `rts_no` is high while receive is disabled. It goes low as soon as `rx_en_i` is 1, stays high for the whole of each frame, and is low again when the frame ends. It does not depend on the transmit or receive flags.
- R11: With `ext_clk_sel_i` at 1, frames are clocked by the edges on `sclk_i`. A frame starts only while the synchronized `sclk_i` rests at the idle level set by the polarity.
- R12: Register address 2 reads back the baud value. Address 3 reads status with `overrun` in bit 2, `rx_done` in bit 1 and `tx_empty` in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| cont_rx_i | input | 1 | Continuous receive mode |
| cts_en_i | input | 1 | Enable clear-to-send gating |
| cts_ni | input | 1 | Clear-to-send, active low |
| ext_clk_sel_i | input | 1 | 1 selects the external shift clock |
| clk_pol_i | input | 1 | Shift clock polarity (0 idles high) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| rts_no | output | 1 | Request-to-send, active low |
| tx_empty_o | output | 1 | Transmit buffer empty |
| rx_done_o | output | 1 | Receive complete |
| overrun_o | output | 1 | Overrun error, sticky |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
A slipped bit counter or shift register shows up within the same frame. The byte on `txd_o` comes out rotated, and the value read from the receive buffer right after the frame is wrong. A wrong start condition also shows at once: `sclk_o` edges appear while the bench holds transmit enable, clear-to-send or the external clock level against a start, or a pending byte never leaves and `tx_empty_o` stays low. Flag faults, such as a missing or doubled interrupt, an overrun that is not raised, or a stuck receive-complete flag, show on the status outputs within a few cycles after the last trailing edge of the frame.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_TXBUF = 2'd0,
    REG_RXBUF = 2'd1,
    REG_BAUD  = 2'd2,
    REG_STAT  = 2'd3
  } csio_reg_e;
endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int unsigned BAUD_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_sel_i,
  input  logic              pol_i,
  input  logic              active_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              sclk_i,
  output logic              lead_o,
  output logic              trail_o,
  output logic              sclk_o,
  output logic              ext_idle_o
);
  logic              idle_lvl;
  logic [BAUD_W-1:0] div_q;
  logic              sclk_q;
  logic [SYNC_N:0]   sync_q;
  logic              int_tick, ext_rise, ext_fall, ext_lvl;

  assign idle_lvl = ~pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-1:0], sclk_i};
      if (!active_i || ext_sel_i) begin
        div_q  <= '0;
        sclk_q <= idle_lvl;
      end else if (div_q == baud_i) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign int_tick = active_i && !ext_sel_i && (div_q == baud_i);
  assign ext_lvl  = sync_q[SYNC_N-1];
  assign ext_rise = ext_lvl & ~sync_q[SYNC_N];
  assign ext_fall = ~ext_lvl & sync_q[SYNC_N];

  // leading edge leaves the idle level and changes data; trailing edge samples
  assign lead_o  = (int_tick && (sclk_q == idle_lvl)) ||
                   (active_i && ext_sel_i && (pol_i ? ext_rise : ext_fall));
  assign trail_o = (int_tick && (sclk_q != idle_lvl)) ||
                   (active_i && ext_sel_i && (pol_i ? ext_fall : ext_rise));

  assign sclk_o     = ext_sel_i ? idle_lvl : sclk_q;
  assign ext_idle_o = (ext_lvl == idle_lvl);
endmodule

// File: rtl/csio_shift.sv
module csio_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              rxd_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic [DATA_W-1:0] word_o,
  output logic              near_end_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(DATA_W);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              busy_q, txd_q, near_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      near_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      near_q <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        tx_sh  <= load_i;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (lead_i) begin
          txd_q <= tx_sh[0];
          tx_sh <= {1'b1, tx_sh[DATA_W-1:1]};
        end
        if (trail_i) begin
          rx_sh <= {rxd_i, rx_sh[DATA_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(DATA_W-2)) near_q <= 1'b1;
          if (cnt_q == CW'(DATA_W-1)) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign txd_o      = txd_q;
  assign word_o     = rx_sh;
  assign near_end_o = near_q;
  assign done_o     = done_q;
endmodule

// File: rtl/csio_rxbuf.sv
module csio_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              cont_i,
  input  logic              start_i,
  input  logic              near_end_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              irq_o,
  output logic              rearm_o
);
  logic [DATA_W-1:0] buf_q;
  logic full_q, ovr_q, frame_ovr_q, irq_q, rearm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q       <= '0;
      full_q      <= 1'b0;
      ovr_q       <= 1'b0;
      frame_ovr_q <= 1'b0;
      irq_q       <= 1'b0;
      rearm_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (start_i) begin
        frame_ovr_q <= 1'b0;
        rearm_q     <= 1'b0;
      end
      if (near_end_i && rx_en_i && full_q) begin
        ovr_q       <= 1'b1;
        frame_ovr_q <= 1'b1;
      end
      if (done_i && rx_en_i) begin
        buf_q  <= word_i;
        full_q <= 1'b1;
        irq_q  <= ~frame_ovr_q;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (rd_i && cont_i) rearm_q <= 1'b1;
      if (!rx_en_i) ovr_q <= 1'b0;
    end
  end

  assign buf_o     = buf_q;
  assign full_o    = full_q;
  assign overrun_o = ovr_q;
  assign irq_o     = irq_q;
  assign rearm_o   = rearm_q;
endmodule

// File: rtl/csio_top.sv
module csio_top
  import csio_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BAUD_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              cont_rx_i,
  input  logic              cts_en_i,
  input  logic              cts_ni,
  input  logic              ext_clk_sel_i,
  input  logic              clk_pol_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rts_no,
  output logic              tx_empty_o,
  output logic              rx_done_o,
  output logic              overrun_o,
  output logic              rx_irq_o
);
  logic [DATA_W-1:0] tx_buf_q, rx_word, rx_buf;
  logic [BAUD_W-1:0] baud_q;
  logic tx_full_q, busy, start, lead, trail, ext_idle;
  logic near_end, done, rearm, rd_rx, cts_ok;

  assign cts_ok = !cts_en_i || !cts_ni;
  assign start  = !busy && tx_en_i && (tx_full_q || rearm) && cts_ok &&
                  (!ext_clk_sel_i || ext_idle);
  assign rd_rx  = rd_en_i && (addr_i == REG_RXBUF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      baud_q    <= '0;
    end else begin
      if (wr_en_i && addr_i == REG_TXBUF) begin
        tx_buf_q  <= wdata_i;
        tx_full_q <= 1'b1;
      end else if (start) begin
        tx_full_q <= 1'b0;
      end
      if (wr_en_i && addr_i == REG_BAUD) baud_q <= wdata_i[BAUD_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      REG_TXBUF: rdata_o = tx_buf_q;
      REG_RXBUF: rdata_o = rx_buf;
      REG_BAUD:  rdata_o = DATA_W'(baud_q);
      REG_STAT:  rdata_o = DATA_W'({overrun_o, rx_done_o, ~tx_full_q});
      default:   rdata_o = '0;
    endcase
  end

  csio_clkgen #(.BAUD_W(BAUD_W), .SYNC_N(SYNC_N)) u_clk (
    .clk_i, .rst_ni,
    .ext_sel_i (ext_clk_sel_i),
    .pol_i     (clk_pol_i),
    .active_i  (busy),
    .baud_i    (baud_q),
    .sclk_i,
    .lead_o    (lead),
    .trail_o   (trail),
    .sclk_o,
    .ext_idle_o(ext_idle)
  );

  csio_shift #(.DATA_W(DATA_W)) u_sh (
    .clk_i, .rst_ni,
    .start_i   (start),
    .load_i    (tx_buf_q),
    .lead_i    (lead),
    .trail_i   (trail),
    .rxd_i,
    .busy_o    (busy),
    .txd_o,
    .word_o    (rx_word),
    .near_end_o(near_end),
    .done_o    (done)
  );

  csio_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .rx_en_i,
    .cont_i    (cont_rx_i),
    .start_i   (start),
    .near_end_i(near_end),
    .done_i    (done),
    .word_i    (rx_word),
    .rd_i      (rd_rx),
    .buf_o     (rx_buf),
    .full_o    (rx_done_o),
    .overrun_o,
    .irq_o     (rx_irq_o),
    .rearm_o   (rearm)
  );

  assign rts_no     = ~rx_en_i | busy;
  assign tx_empty_o = ~tx_full_q;
endmodule

// File: rtl/csio_chk.sv
module csio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       cts_en_i,
  input logic       cts_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic       busy_i,
  input logic       tx_empty_i,
  input logic       rx_irq_i,
  input logic       rx_done_i,
  input logic       overrun_i
);
  assert_start_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(tx_en_i));

  assert_cts_gates_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!cts_en_i || !cts_ni));

  assert_empty_falls_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_i) |-> $past(wr_en_i && addr_i == 2'd0));

  assert_irq_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_i |-> rx_done_i);

  assert_overrun_needs_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_i) |-> $past(rx_done_i));
endmodule

bind csio_top csio_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .cts_en_i  (cts_en_i),
  .cts_ni    (cts_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .busy_i    (busy),
  .tx_empty_i(tx_empty_o),
  .rx_irq_i  (rx_irq_o),
  .rx_done_i (rx_done_o),
  .overrun_i (overrun_o)
);

// File: tb/sim_csio_top.sv
`timescale 1ns/1ps
module sim_csio_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic tx_en = 0, rx_en = 0, cont_rx = 0, cts_en = 0, cts_n = 1;
  logic ext_sel = 0, clk_pol = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sclk_drv = 1'b1, sclk_o, txd, rxd = 1'b1;
  logic rts_n, tx_empty, rx_done, overrun, rx_irq;

  csio_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .cont_rx_i(cont_rx), .cts_en_i(cts_en), .cts_ni(cts_n),
    .ext_clk_sel_i(ext_sel), .clk_pol_i(clk_pol), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sclk_i(sclk_drv), .sclk_o(sclk_o), .txd_o(txd), .rxd_i(rxd),
    .rts_no(rts_n), .tx_empty_o(tx_empty), .rx_done_o(rx_done),
    .overrun_o(overrun), .rx_irq_o(rx_irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0;
  int edges = 0, bitn = 0, frames = 0, last_edge = 0, hp = 0;
  logic [7:0] cap = '0, cur_rx = '0, expv;
  bit mon_on = 1'b1;
  logic prev_line = 1'b1;
  logic [7:0] txq[$];
  wire line_clk = ext_sel ? sclk_drv : sclk_o;
  wire idle_lvl = ~clk_pol;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: plays the far end, checks txd frames against the queue
  always @(negedge clk) begin
    cyc++;
    if (rx_irq) irq_cnt++;
    if (mon_on && line_clk != prev_line) begin
      edges++;
      hp = cyc - last_edge;
      last_edge = cyc;
      if (line_clk != idle_lvl) begin
        rxd <= cur_rx[bitn];
      end else begin
        cap[bitn] = txd;
        if (rx_en && bitn == 3) chk(rts_n == 1'b1, "R10 rts high in frame", rts_n, 1);
        bitn++;
        if (bitn == 8) begin
          bitn = 0;
          frames++;
          if (txq.size() == 0) chk(1'b0, "R2 unexpected frame", cap, 0);
          else begin
            expv = txq.pop_front();
            chk(cap == expv, "R2 txd frame LSB first", cap, expv);
          end
        end
      end
    end
    prev_line = line_clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] r);
    txq.push_back(t);
    cur_rx = r;
    reg_wr(2'd0, t);
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic ext_frame();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 sclk_drv = clk_pol;
      repeat (8) @(negedge clk);
      #1 sclk_drv = ~clk_pol;
      repeat (7) @(negedge clk);
    end
  endtask

  logic [7:0] d;
  int e0, ib;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R4 reset empty", tx_empty, 1);
    chk(rx_done == 1'b0, "R5 reset done", rx_done, 0);
    chk(overrun == 1'b0, "R6 reset overrun", overrun, 0);
    chk(rts_n == 1'b1, "R10 rts high rx disabled", rts_n, 1);
    chk(sclk_o == 1'b1, "R3 idle high pol0", sclk_o, 1);

    reg_wr(2'd2, 8'd3);
    reg_rd(2'd2, d);
    chk(d == 8'd3, "R12 baud readback", d, 3);

    // R1: byte pending but transmit disabled
    reg_wr(2'd0, 8'hA5);
    repeat (40) @(negedge clk);
    chk(edges == 0, "R1 no clock without tx enable", edges, 0);
    chk(tx_empty == 1'b0, "R4 write clears empty", tx_empty, 0);
    rx_en = 1; #1;
    chk(rts_n == 1'b0, "R10 rts low on rx enable", rts_n, 0);
    txq.push_back(8'hA5); cur_rx = 8'h3C;
    tx_en = 1;
    wait_frames(1);
    chk(tx_empty == 1'b1, "R4 empty after load", tx_empty, 1);
    chk(rx_done == 1'b1, "R5 done set", rx_done, 1);
    chk(irq_cnt == 1, "R5 one irq pulse", irq_cnt, 1);
    chk(rts_n == 1'b0, "R10 rts low after frame", rts_n, 0);
    chk(hp == 4, "R2 half period baud+1", hp, 4);
    reg_rd(2'd1, d);
    chk(d == 8'h3C, "R2 rx LSB first", d, 8'h3C);
    chk(rx_done == 1'b0, "R5 cleared by read", rx_done, 0);
    e0 = edges;
    repeat (40) @(negedge clk);
    chk(edges == e0, "R7 read alone starts no frame", edges, e0);

    // R3: polarity 1
    mon_on = 0; clk_pol = 1; repeat (4) @(negedge clk);
    chk(sclk_o == 1'b0, "R3 idle low pol1", sclk_o, 0);
    mon_on = 1;
    send(8'h81, 8'hC3);
    wait_frames(2);
    reg_rd(2'd1, d);
    chk(d == 8'hC3, "R3 pol1 rx data", d, 8'hC3);
    mon_on = 0; clk_pol = 0; repeat (4) @(negedge clk); mon_on = 1;

    // R6: overrun
    send(8'h11, 8'h22);
    wait_frames(3);
    ib = irq_cnt;
    send(8'h33, 8'h44);
    wait_frames(4);
    chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
    chk(irq_cnt == ib, "R6 no irq on overrun", irq_cnt, ib);
    reg_rd(2'd1, d);
    chk(d == 8'h44, "R6 buffer overwritten", d, 8'h44);
    reg_rd(2'd3, d);
    chk(d == 8'h05, "R12 status bits", d, 8'h05);
    rx_en = 0; repeat (2) @(negedge clk);
    chk(overrun == 1'b0, "R6 cleared by rx disable", overrun, 0);
    rx_en = 1;

    // R8: continuous receive
    cont_rx = 1;
    send(8'h5A, 8'h96);
    wait_frames(5);
    txq.push_back(8'h5A);
    reg_rd(2'd1, d);
    cur_rx = 8'h69;
    chk(d == 8'h96, "R8 first frame rx", d, 8'h96);
    wait_frames(6);
    chk(rx_done == 1'b1, "R8 rearmed frame done", rx_done, 1);
    cont_rx = 0;
    reg_rd(2'd1, d);
    chk(d == 8'h69, "R8 frame without write", d, 8'h69);
    e0 = edges;
    repeat (40) @(negedge clk);
    chk(edges == e0, "R7 no rearm outside continuous", edges, e0);

    // R9: clear-to-send
    cts_en = 1; cts_n = 1;
    send(8'h0F, 8'hF0);
    e0 = edges;
    repeat (40) @(negedge clk);
    chk(edges == e0, "R9 held by cts", edges, e0);
    chk(tx_empty == 1'b0, "R9 byte pending", tx_empty, 0);
    cts_n = 0;
    wait_frames(7);
    reg_rd(2'd1, d);
    chk(d == 8'hF0, "R9 frame after cts", d, 8'hF0);
    cts_en = 0;

    // R11: external clock
    mon_on = 0; ext_sel = 1; sclk_drv = 1'b0;
    repeat (5) @(negedge clk);
    send(8'hC6, 8'h3B);
    repeat (20) @(negedge clk);
    chk(tx_empty == 1'b0, "R11 no start off idle", tx_empty, 0);
    sclk_drv = 1'b1;
    repeat (10) @(negedge clk);
    chk(tx_empty == 1'b1, "R11 start at idle", tx_empty, 1);
    mon_on = 1;
    ext_frame();
    wait_frames(8);
    chk(rx_done == 1'b1, "R11 ext frame done", rx_done, 1);
    reg_rd(2'd1, d);
    chk(d == 8'h3B, "R11 ext rx data", d, 8'h3B);
    chk(txq.size() == 0, "R2 all frames seen", txq.size(), 0);

    finish_run();
  end
endmodule